// File: doc/BRIEF.md
# Prioritizing Channel-Mapped Interrupt Controller

This block collects 32 system interrupt lines and presents them to a processor as two host request lines: a fast request and a normal request. Each line is synchronized, conditioned by a programmable polarity and a level or edge type, and held in a status bit. A status bit counts as pending only when the line's enable bit is also set. Each line carries an 8-bit channel number that fixes its priority and its host. Channels 0 and 1 go to the fast host, and channels 2 to 31 go to the normal host.

Software reaches the block over a plain 32-bit register bus. Writes are captured on the rising clock edge when the write strobe is high. Reads return data combinationally for the current address. Single status or enable bits are set and cleared by writing an interrupt number to an index register. Whole words are cleared, or enables set, with write-one masks. For each host, a prioritized-index register reports the winning interrupt number, so a handler reads one word to learn which source to serve.

All byte addresses are word aligned and 14 bits wide.

Top module: `chan_prio_intc`

## Requirements
- R1: After reset, these all read zero: status (0x200), enables (0x300), channel map (0x400 to 0x41C), global enable (0x010) and host enables (0x1500). Polarity (0xD00) reads 0xFFFFFFFF and type (0xD80) reads 0. Both host outputs are low, and both prioritized-index words (0x900, 0x904) read 0x80000000.
- R2: An input change passes a two-flop synchronizer into the status register. A host output reflects it after the third rising clock edge that follows the change, and not after the second.
- R3: For a line whose type bit is 1 (edge), status is set on the edge chosen by its polarity bit: 1 selects rising, 0 selects falling. The status bit stays set after the input returns, until software clears it.
- R4: For a line whose type bit is 0 (level), status follows the active level every cycle: polarity 1 means active-high and polarity 0 means active-low. A software index-set has no lasting effect on such a line.
- R5: Writing interrupt number n (bits 4:0) to 0x020 sets status bit n. Writing n to 0x024 clears only status bit n. Writing a mask to 0x280 clears every status bit written as 1.
- R6: Writing n to 0x028 sets enable bit n, and writing n to 0x02C clears only enable bit n. Masks written to 0x300 set, and masks written to 0x380 clear, every enable bit written as 1. Both 0x300 and 0x380 read back the enable word.
- R7: Interrupt 4k+j takes its channel from byte j (bits 8j+7:8j) of the map word at 0x400+4k. A channel value above 31 routes the line to no host.
- R8: Among pending enabled lines on one host, the lowest channel number wins. On equal channels, the lowest interrupt number wins.
- R9: Channels 0 and 1 drive only the fast output. Channels 2 to 31 drive only the normal output.
- R10: Bit 0 of 0x010 gates both outputs. Writing host number h (0 = fast, 1 = normal) to 0x034 enables host h, and writing it to 0x038 disables host h. Host enables read back at 0x1500, bits 1:0.
- R11: The word at 0x900 (fast) and the word at 0x904 (normal) each hold the winning interrupt number in bits 4:0, with bit 31 set when that host has no candidate. This word ignores the global and host enables.
- R12: Polarity (0xD00) and type (0xD80) are read/write words, one bit per line. Reads of unimplemented addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 14 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| irq_in | input | 32 | Raw system interrupt lines |
| fast_irq | output | 1 | Fast host request (channels 0 and 1) |
| norm_irq | output | 1 | Normal host request (channels 2 to 31) |

## Verification
The bench checks the host output one cycle before and exactly at the third edge after an input change. A synchronizer that is too short or too long shows up there as an early or late request. Tie-breaking is tested with two lines on the same channel and a higher-numbered line on a better channel, which exposes a resolver that favours index over channel or that keeps the last match instead of the first. An edge line is driven against the opposite polarity to catch a detector that fires on both edges. Out-of-range channel values, gating by the global and host enables, and an index-set on a level line are each checked, because a design that got them wrong would raise a request, hide the winning index or keep a stale status bit.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC      = 32;
    localparam int SRC_IDX_W = $clog2(NSRC);
    localparam int CHAN_W    = 8;
    localparam int NHOST     = 2;
    localparam int AW        = 14;

    localparam logic [AW-1:0] A_GLB_EN  = 14'h0010;
    localparam logic [AW-1:0] A_ST_ISET = 14'h0020;
    localparam logic [AW-1:0] A_ST_ICLR = 14'h0024;
    localparam logic [AW-1:0] A_EN_ISET = 14'h0028;
    localparam logic [AW-1:0] A_EN_ICLR = 14'h002C;
    localparam logic [AW-1:0] A_HE_ISET = 14'h0034;
    localparam logic [AW-1:0] A_HE_ICLR = 14'h0038;
    localparam logic [AW-1:0] A_ST_RAW  = 14'h0200;
    localparam logic [AW-1:0] A_ST_BCLR = 14'h0280;
    localparam logic [AW-1:0] A_EN_BSET = 14'h0300;
    localparam logic [AW-1:0] A_EN_BCLR = 14'h0380;
    localparam logic [AW-1:0] A_MAP     = 14'h0400;
    localparam logic [AW-1:0] A_PRIO0   = 14'h0900;
    localparam logic [AW-1:0] A_PRIO1   = 14'h0904;
    localparam logic [AW-1:0] A_POL     = 14'h0D00;
    localparam logic [AW-1:0] A_TYPE    = 14'h0D80;
    localparam logic [AW-1:0] A_HE_RD   = 14'h1500;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic rise_act,
    output logic edge_evt,
    output logic lvl_act
);
    // pipe[SYNC_STAGES-1] is the synchronized value, pipe[SYNC_STAGES] its previous cycle
    logic [SYNC_STAGES:0] pipe;
    logic s_now, s_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC_STAGES-1:0], raw};
    end

    assign s_now  = pipe[SYNC_STAGES-1];
    assign s_prev = pipe[SYNC_STAGES];

    always_comb begin
        if (rise_act) begin
            edge_evt = s_now & ~s_prev;
            lvl_act  = s_now;
        end else begin
            edge_evt = ~s_now & s_prev;
            lvl_act  = ~s_now;
        end
    end

    // R3: a selected edge yields a single-cycle event while polarity is held
    a_r3_one_cycle_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt && $stable(rise_act)) |=> (!edge_evt || (rise_act != $past(rise_act))));
endmodule

// File: rtl/intc_prio_res.sv
module intc_prio_res
    import intc_pkg::*;
#(
    parameter int CH_LO = 0,
    parameter int CH_HI = 1
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*CHAN_W-1:0] chan_flat,
    output logic                   hit,
    output logic [SRC_IDX_W-1:0]   win_idx
);
    logic [CHAN_W-1:0] best;
    logic [CHAN_W-1:0] ch;

    // Strict less-than keeps the first (lowest-numbered) line on equal channels
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        best    = '1;
        ch      = '0;
        for (int i = 0; i < NSRC; i++) begin
            ch = chan_flat[i*CHAN_W +: CHAN_W];
            if (cand[i] && int'(ch) >= CH_LO && int'(ch) <= CH_HI && (!hit || ch < best)) begin
                hit     = 1'b1;
                win_idx = SRC_IDX_W'(i);
                best    = ch;
            end
        end
    end

    logic [CHAN_W-1:0] win_ch;
    assign win_ch = chan_flat[{win_idx, 3'b000} +: CHAN_W];

    always_comb begin
        a_r8_winner_pending: assert (!hit || cand[win_idx]);
        a_r9_winner_in_range: assert (!hit || (int'(win_ch) >= CH_LO && int'(win_ch) <= CH_HI));
    end
endmodule

// File: rtl/chan_prio_intc.sv
module chan_prio_intc
    import intc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FAST_CHANS  = 2,
    parameter int NUM_CHAN    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            fast_irq,
    output logic            norm_irq
);
    localparam int MAP_WORDS = NSRC * CHAN_W / 32;
    localparam int MAP_SEL_W = $clog2(MAP_WORDS);
    localparam int HOST_W    = $clog2(NHOST);

    logic                   glb_en;
    logic [NHOST-1:0]       host_en;
    logic [NSRC-1:0]        en_r, pol_r, type_r, status;
    logic [NSRC*CHAN_W-1:0] chan_flat;
    logic [NSRC-1:0]        edge_evt, lvl_act, pend;

    // ---------------- write decode ----------------
    logic w_glb, w_st_iset, w_st_iclr, w_en_iset, w_en_iclr, w_he_iset, w_he_iclr;
    logic w_st_bclr, w_en_bset, w_en_bclr, w_pol, w_type, map_hit, w_map;
    logic [MAP_SEL_W-1:0] map_sel;
    logic [NSRC-1:0]      idx_hot, st_set, st_clr, en_set, en_clr;

    assign w_glb     = bus_we && (bus_addr == A_GLB_EN);
    assign w_st_iset = bus_we && (bus_addr == A_ST_ISET);
    assign w_st_iclr = bus_we && (bus_addr == A_ST_ICLR);
    assign w_en_iset = bus_we && (bus_addr == A_EN_ISET);
    assign w_en_iclr = bus_we && (bus_addr == A_EN_ICLR);
    assign w_he_iset = bus_we && (bus_addr == A_HE_ISET);
    assign w_he_iclr = bus_we && (bus_addr == A_HE_ICLR);
    assign w_st_bclr = bus_we && (bus_addr == A_ST_BCLR);
    assign w_en_bset = bus_we && (bus_addr == A_EN_BSET);
    assign w_en_bclr = bus_we && (bus_addr == A_EN_BCLR);
    assign w_pol     = bus_we && (bus_addr == A_POL);
    assign w_type    = bus_we && (bus_addr == A_TYPE);
    assign map_hit   = (bus_addr[AW-1:MAP_SEL_W+2] == A_MAP[AW-1:MAP_SEL_W+2]) &&
                       (bus_addr[1:0] == 2'b00);
    assign w_map     = bus_we && map_hit;
    assign map_sel   = bus_addr[MAP_SEL_W+1:2];

    assign idx_hot = {{(NSRC-1){1'b0}}, 1'b1} << bus_wdata[SRC_IDX_W-1:0];
    assign st_set  = w_st_iset ? idx_hot : '0;
    assign st_clr  = (w_st_iclr ? idx_hot : '0) | (w_st_bclr ? bus_wdata : '0);
    assign en_set  = (w_en_iset ? idx_hot : '0) | (w_en_bset ? bus_wdata : '0);
    assign en_clr  = (w_en_iclr ? idx_hot : '0) | (w_en_bclr ? bus_wdata : '0);

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en    <= 1'b0;
            host_en   <= '0;
            en_r      <= '0;
            pol_r     <= '1;
            type_r    <= '0;
            chan_flat <= '0;
        end else begin
            if (w_glb) glb_en <= bus_wdata[0];
            if (w_he_iset && bus_wdata < 32'(NHOST)) host_en[bus_wdata[HOST_W-1:0]] <= 1'b1;
            if (w_he_iclr && bus_wdata < 32'(NHOST)) host_en[bus_wdata[HOST_W-1:0]] <= 1'b0;
            en_r <= (en_r | en_set) & ~en_clr;
            if (w_pol)  pol_r  <= bus_wdata;
            if (w_type) type_r <= bus_wdata;
            if (w_map)  chan_flat[{map_sel, 5'b00000} +: 32] <= bus_wdata;
        end
    end

    // ---------------- per-line conditioning and status ----------------
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        intc_src_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (irq_in[i]),
            .rise_act (pol_r[i]),
            .edge_evt (edge_evt[i]),
            .lvl_act  (lvl_act[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (!type_r[i]) status[i] <= lvl_act[i];
            else                 status[i] <= edge_evt[i] | st_set[i] | (status[i] & ~st_clr[i]);
        end
    end

    assign pend = status & en_r;

    // ---------------- per-host resolution ----------------
    logic [NHOST-1:0]     host_vld;
    logic [SRC_IDX_W-1:0] host_idx [NHOST];
    logic [31:0]          prio_word [NHOST];

    for (genvar h = 0; h < NHOST; h++) begin : g_host
        localparam int LO = (h == 0) ? 0 : FAST_CHANS;
        localparam int HI = (h == 0) ? FAST_CHANS - 1 : NUM_CHAN - 1;
        intc_prio_res #(.CH_LO(LO), .CH_HI(HI)) u_res (
            .cand      (pend),
            .chan_flat (chan_flat),
            .hit       (host_vld[h]),
            .win_idx   (host_idx[h])
        );
        assign prio_word[h] = {~host_vld[h], {(31-SRC_IDX_W){1'b0}}, host_idx[h]};
    end

    assign fast_irq = glb_en & host_en[0] & host_vld[0];
    assign norm_irq = glb_en & host_en[1] & host_vld[1];

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (map_hit) begin
            bus_rdata = chan_flat[{map_sel, 5'b00000} +: 32];
        end else begin
            case (bus_addr)
                A_GLB_EN:             bus_rdata = {31'b0, glb_en};
                A_HE_RD:              bus_rdata = 32'(host_en);
                A_ST_RAW:             bus_rdata = status;
                A_EN_BSET, A_EN_BCLR: bus_rdata = en_r;
                A_POL:                bus_rdata = pol_r;
                A_TYPE:               bus_rdata = type_r;
                A_PRIO0:              bus_rdata = prio_word[0];
                A_PRIO1:              bus_rdata = prio_word[1];
                default:              bus_rdata = '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R10: the global enable gates both host requests
    a_r10_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (!fast_irq && !norm_irq));

    // R3: an edge-type status bit holds while no bus write occurs
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((status & $past(status & type_r)) == $past(status & type_r)));

    // R4: a level-type status bit tracks the conditioned level one cycle later
    a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((status & ~type_r) == ($past(lvl_act) & ~type_r)));
endmodule

// File: tb/chan_prio_intc_tb.sv
module chan_prio_intc_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        fast_irq, norm_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    chan_prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .fast_irq(fast_irq), .norm_irq(norm_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [13:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic settle;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 14'h200, 32'h0);
        rd_chk("R1 enable", 14'h300, 32'h0);
        rd_chk("R1 map",    14'h41C, 32'h0);
        rd_chk("R1 glb",    14'h010, 32'h0);
        rd_chk("R1 hosten", 14'h1500, 32'h0);
        rd_chk("R1 pol",    14'hD00, 32'hFFFFFFFF);
        rd_chk("R1 type",   14'hD80, 32'h0);
        rd_chk("R1 prio0",  14'h900, 32'h80000000);
        rd_chk("R1 prio1",  14'h904, 32'h80000000);
        chk("R1 outs", {30'b0, fast_irq, norm_irq}, 32'h0);
    endtask

    task automatic t_unmapped;
        rd_chk("R12 unmapped 0x008", 14'h008, 32'h0);
        rd_chk("R12 unmapped 0x1234", 14'h1234, 32'h0);
        wr(14'hD00, 32'h12345678);
        rd_chk("R12 pol rw", 14'hD00, 32'h12345678);
        wr(14'hD00, 32'hFFFFFFFF);
    endtask

    task automatic t_host_setup;
        wr(14'h010, 32'h1);
        wr(14'h034, 32'h0);
        wr(14'h034, 32'h1);
        rd_chk("R10 hosten both", 14'h1500, 32'h3);
        rd_chk("R10 glb", 14'h010, 32'h1);
    endtask

    task automatic t_level;
        wr(14'h028, 32'd5);
        rd_chk("R6 idx enable", 14'h300, 32'h20);
        @(negedge clk); irq_in[5] = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R2 not after 2nd edge", {31'b0, fast_irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R2 after 3rd edge", {31'b0, fast_irq}, 32'h1);
        chk("R9 chan0 not normal", {31'b0, norm_irq}, 32'h0);
        irq_in[5] = 1'b0;
        settle();
        chk("R4 level released", {31'b0, fast_irq}, 32'h0);
        wr(14'h020, 32'd5);
        rd_chk("R4 index-set ignored on level", 14'h200, 32'h0);
    endtask

    task automatic t_edge;
        wr(14'hD80, 32'h200);
        @(negedge clk); irq_in[9] = 1'b1;
        repeat (2) @(negedge clk); irq_in[9] = 1'b0;
        settle();
        rd_chk("R3 rising held", 14'h200, 32'h200);
        wr(14'h024, 32'd9);
        rd_chk("R5 index clear", 14'h200, 32'h0);
        wr(14'hD00, 32'hFFFFFDFF);
        @(negedge clk); irq_in[9] = 1'b1;
        settle();
        rd_chk("R3 rising ignored in falling mode", 14'h200, 32'h0);
        irq_in[9] = 1'b0;
        settle();
        rd_chk("R3 falling sets", 14'h200, 32'h200);
        wr(14'h024, 32'd9);
    endtask

    task automatic t_index;
        wr(14'hD80, 32'hFFFFFFFF);
        wr(14'h280, 32'hFFFFFFFF);
        wr(14'h020, 32'd12);
        wr(14'h020, 32'd20);
        rd_chk("R5 index set", 14'h200, 32'h00101000);
        wr(14'h024, 32'd12);
        rd_chk("R5 index clear one", 14'h200, 32'h00100000);
        wr(14'h280, 32'h00100000);
        rd_chk("R5 bulk clear", 14'h200, 32'h0);
        wr(14'h380, 32'hFFFFFFFF);
        rd_chk("R6 bulk clear all", 14'h300, 32'h0);
        wr(14'h300, 32'hF0);
        wr(14'h380, 32'h30);
        rd_chk("R6 bulk set/clear", 14'h380, 32'hC0);
        wr(14'h028, 32'd3);
        wr(14'h02C, 32'd7);
        rd_chk("R6 index set/clear", 14'h300, 32'h48);
    endtask

    task automatic t_prio;
        wr(14'h300, 32'hFFFFFFFF);
        wr(14'h400, 32'h00000001);
        wr(14'h404, 32'h00030005);
        wr(14'h408, 32'h0003001F);
        wr(14'h410, 32'h00002800);
        rd_chk("R7 map readback", 14'h404, 32'h00030005);
        wr(14'h020, 32'd8);
        rd_chk("R9 chan31 normal", 14'h904, 32'd8);
        chk("R9 norm high fast low", {30'b0, fast_irq, norm_irq}, 32'h1);
        rd_chk("R11 fast empty", 14'h900, 32'h80000000);
        wr(14'h020, 32'd4);
        rd_chk("R8 lower channel wins", 14'h904, 32'd4);
        wr(14'h020, 32'd10);
        rd_chk("R8 higher index better channel", 14'h904, 32'd10);
        wr(14'h020, 32'd6);
        rd_chk("R8 tie lowest index", 14'h904, 32'd6);
        wr(14'h020, 32'd0);
        rd_chk("R9 chan1 fast", 14'h900, 32'd0);
        chk("R9 fast high", {31'b0, fast_irq}, 32'h1);
        wr(14'h280, 32'hFFFFFFFF);
        wr(14'h020, 32'd17);
        rd_chk("R7 chan40 routes nowhere", 14'h904, 32'h80000000);
        chk("R7 no request", {30'b0, fast_irq, norm_irq}, 32'h0);
        wr(14'h280, 32'hFFFFFFFF);
    endtask

    task automatic t_gate;
        wr(14'h020, 32'd6);
        chk("R10 norm raised", {31'b0, norm_irq}, 32'h1);
        wr(14'h010, 32'h0);
        chk("R10 global off", {31'b0, norm_irq}, 32'h0);
        rd_chk("R11 index ignores enables", 14'h904, 32'd6);
        wr(14'h010, 32'h1);
        wr(14'h038, 32'd1);
        chk("R10 host off", {31'b0, norm_irq}, 32'h0);
        rd_chk("R10 hosten readback", 14'h1500, 32'h1);
        wr(14'h034, 32'd1);
        chk("R10 host on", {31'b0, norm_irq}, 32'h1);
        wr(14'h02C, 32'd6);
        rd_chk("R6 disabled line drops", 14'h904, 32'h80000000);
        chk("R6 norm low", {31'b0, norm_irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_host_setup();
        t_level();
        t_edge();
        t_index();
        t_prio();
        t_gate();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule